// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Transfer Engine

This block is one channel of a data mover. Software loads a source address, a destination address, a control word and a count word through a small write-only register port. A trigger then starts a block. The block moves elements of 1, 2 or 4 bytes over a simple 32-bit master bus. Each element is one bus read from the source followed by one bus write of the same bytes to the destination. A block is made of a number of major iterations. Each major iteration carries a minor byte count.

A trigger can come from four places: a software command bit, a peripheral request pin, a periodic tick pin or a link pin from another channel. The three pins each have their own enable bit. Both addresses can step by the element size or stay fixed. A circular option sends both addresses back to their programmed values at the end of a block. Without it, the next block carries on from where the last one stopped. Sticky flags report completion, a start that was dropped and an error. The completion flag can raise an interrupt.

Top module: `dma_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `ovr_o`, `irq_o` and `mst_req_o` are all low.
- R2: Register 2 (control) bits [1:0] select the element size: 0 is one byte, 1 is two bytes, 2 is four bytes. Each bus cycle enables exactly that many byte lanes, starting at lane addr[1:0] (little-endian). The bytes read at the source lanes are written at the destination lanes.
- R3: Control bit 2 makes the source address advance by the element size after each element. Control bit 3 does the same for the destination. When a bit is clear, that address stays constant.
- R4: Every element is one read (`mst_we_o`=0) followed by one write (`mst_we_o`=1) of the read data. The next read is issued only after that write has been acknowledged.
- R5: Register 3 (count) holds the minor byte count in bits [15:0] and the major count in bits [31:16]. A block moves major × minor/size elements. A single-value transfer uses major 1 and a minor count equal to the size.
- R6: With control bit 4 set, both working addresses return to the values last written to register 0 (source) and register 1 (destination) when a block ends. With the bit clear, the next block continues from the addresses where the last block stopped.
- R7: A block starts in any of these cases: a write to register 4 with bit 0 set; `hw_req_i` high while control bit 6 is set; `timer_tick_i` high while control bit 7 is set; or `link_req_i` high while control bit 8 is set. A pin whose enable bit is clear has no effect.
- R8: `done_o` goes high when a block completes. Writing register 4 with bit 1 set clears it. `irq_o` is high exactly when `done_o` and control bit 5 are both high.
- R9: A trigger that arrives while `busy_o` is high is ignored and sets the sticky `ovr_o`. Writing register 4 with bit 3 set clears `ovr_o`.
- R10: A trigger is refused and `err_o` is set, with no bus cycle, if any of these holds: the size code is 3; the source, the destination or the minor count is not a multiple of the size; or either count is zero. Writing register 4 with bit 2 set clears `err_o`.
- R11: An acknowledge that comes with `mst_err_i` high sets `err_o` and ends the block at once. `done_o` is not set.
- R12: While `mst_req_o` is high and not yet acknowledged, address, write enable, byte enables and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 source, 1 destination, 2 control, 3 count, 4 command |
| reg_wdata_i | input | 32 | Register write data |
| hw_req_i | input | 1 | Peripheral request trigger |
| timer_tick_i | input | 1 | Periodic tick trigger |
| link_req_i | input | 1 | Trigger from another channel |
| mst_req_o | output | 1 | Bus cycle request |
| mst_we_o | output | 1 | Bus cycle is a write |
| mst_addr_o | output | 32 | Bus byte address |
| mst_be_o | output | 4 | Byte lane enables |
| mst_wdata_o | output | 32 | Write data |
| mst_rdata_i | input | 32 | Read data, valid with acknowledge |
| mst_ack_i | input | 1 | Bus cycle accepted |
| mst_err_i | input | 1 | Bus error, valid with acknowledge |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | Sticky block-complete flag |
| err_o | output | 1 | Sticky error flag |
| ovr_o | output | 1 | Sticky dropped-trigger flag |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions assume several things about the bus. It acknowledges only a cycle that is being requested. Read data is valid in the acknowledge cycle. `mst_err_i` is high only together with `mst_ack_i`. Triggers are single-cycle pulses. The bench holds to all of this. Its memory model raises acknowledge only while `mst_req_o` is high, and stalls for a random number of cycles. It injects an error only on an acknowledged read. It drives every trigger and register write for exactly one clock. Random configurations keep addresses aligned and counts non-zero. Misalignment appears only in the directed error case.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_e;

  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_CTRL = 3'd2;
  localparam logic [2:0] RA_CNT  = 3'd3;
  localparam logic [2:0] RA_CMD  = 3'd4;

  typedef struct packed {
    logic       link_en;
    logic       tick_en;
    logic       hw_en;
    logic       irq_en;
    logic       circ;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] size;
  } dma_ctrl_t;

  function automatic logic [3:0] lane_mask(input logic [1:0] size);
    case (size)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             set_done_i,
  input  logic             set_err_i,
  input  logic             set_ovr_i,
  output dma_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] minor_o,
  output logic [CNT_W-1:0] major_o,
  output logic             sw_start_o,
  output logic             src_wr_o,
  output logic             dst_wr_o,
  output logic             done_o,
  output logic             err_o,
  output logic             ovr_o
);
  logic cmd_wr;
  assign cmd_wr     = we_i && addr_i == RA_CMD;
  assign sw_start_o = cmd_wr && wdata_i[0];
  assign src_wr_o   = we_i && addr_i == RA_SRC;
  assign dst_wr_o   = we_i && addr_i == RA_DST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      minor_o <= '0;
      major_o <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (we_i && addr_i == RA_CTRL) ctrl_o <= dma_ctrl_t'(wdata_i[$bits(dma_ctrl_t)-1:0]);
      if (we_i && addr_i == RA_CNT) begin
        minor_o <= wdata_i[CNT_W-1:0];
        major_o <= wdata_i[16 +: CNT_W];
      end
      // set wins over a same-cycle clear
      done_o <= set_done_i || (done_o && !(cmd_wr && wdata_i[1]));
      err_o  <= set_err_i  || (err_o  && !(cmd_wr && wdata_i[2]));
      ovr_o  <= set_ovr_i  || (ovr_o  && !(cmd_wr && wdata_i[3]));
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          wrap_i,
  input  logic          inc_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      addr_o <= '0;
    end else if (load_i) begin
      base_q <= load_val_i;
      addr_o <= load_val_i;
    end else if (wrap_i) begin
      addr_o <= base_q;
    end else if (step_i && inc_i) begin
      addr_o <= addr_o + (AW'(1) << size_i);
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             cfg_ok_i,
  input  logic [CNT_W-1:0] minor_elems_i,
  input  logic [CNT_W-1:0] major_i,
  input  logic             circ_i,
  input  logic             ack_i,
  input  logic             berr_i,
  output dma_state_e       state_o,
  output logic             rd_ack_o,
  output logic             step_o,
  output logic             wrap_o,
  output logic             set_done_o,
  output logic             set_err_o,
  output logic             set_ovr_o
);
  logic [CNT_W-1:0] beat_q, maj_q;
  logic busy, last;

  assign busy       = state_o != ST_IDLE;
  assign last       = beat_q == CNT_W'(1) && maj_q == CNT_W'(1);
  assign rd_ack_o   = state_o == ST_RD && ack_i && !berr_i;
  assign step_o     = state_o == ST_WR && ack_i && !berr_i;
  assign wrap_o     = step_o && last && circ_i;
  assign set_done_o = step_o && last;
  assign set_ovr_o  = trig_i && busy;
  assign set_err_o  = (trig_i && !busy && !cfg_ok_i) || (busy && ack_i && berr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      beat_q  <= '0;
      maj_q   <= '0;
    end else begin
      unique case (state_o)
        ST_IDLE: if (trig_i && cfg_ok_i) begin
          state_o <= ST_RD;
          beat_q  <= minor_elems_i;
          maj_q   <= major_i;
        end
        ST_RD: if (ack_i) state_o <= berr_i ? ST_IDLE : ST_WR;
        ST_WR: if (ack_i) begin
          if (berr_i || last) state_o <= ST_IDLE;
          else begin
            state_o <= ST_RD;
            if (beat_q == CNT_W'(1)) begin
              beat_q <= minor_elems_i;
              maj_q  <= maj_q - CNT_W'(1);
            end else begin
              beat_q <= beat_q - CNT_W'(1);
            end
          end
        end
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          hw_req_i,
  input  logic          timer_tick_i,
  input  logic          link_req_i,
  output logic          mst_req_o,
  output logic          mst_we_o,
  output logic [AW-1:0] mst_addr_o,
  output logic [3:0]    mst_be_o,
  output logic [31:0]   mst_wdata_o,
  input  logic [31:0]   mst_rdata_i,
  input  logic          mst_ack_i,
  input  logic          mst_err_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          ovr_o,
  output logic          irq_o
);
  localparam int NCH = 2;  // 0 source, 1 destination

  dma_ctrl_t        cfg_ctrl;
  logic [CNT_W-1:0] minor, major;
  logic             sw_start, trig, cfg_ok, rd_ack, step, wrap;
  logic             set_done, set_err, set_ovr;
  logic [NCH-1:0]   ld, inc;
  logic [AW-1:0]    cur [NCH];
  logic [1:0]       low;
  logic [31:0]      elem_q;
  dma_state_e       state;

  dma_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .set_done_i(set_done), .set_err_i(set_err), .set_ovr_i(set_ovr),
    .ctrl_o(cfg_ctrl), .minor_o(minor), .major_o(major),
    .sw_start_o(sw_start), .src_wr_o(ld[0]), .dst_wr_o(ld[1]),
    .done_o, .err_o, .ovr_o
  );

  assign inc = {cfg_ctrl.dst_inc, cfg_ctrl.src_inc};

  for (genvar g = 0; g < NCH; g++) begin : g_ag
    dma_addr_gen #(.AW(AW)) u_ag (
      .clk_i, .rst_ni,
      .load_i(ld[g]), .load_val_i(reg_wdata_i[AW-1:0]),
      .step_i(step), .wrap_i(wrap), .inc_i(inc[g]),
      .size_i(cfg_ctrl.size), .addr_o(cur[g])
    );
  end

  assign trig = sw_start || (hw_req_i && cfg_ctrl.hw_en)
             || (timer_tick_i && cfg_ctrl.tick_en) || (link_req_i && cfg_ctrl.link_en);

  assign low    = cfg_ctrl.size == 2'd2 ? 2'b11 : (cfg_ctrl.size == 2'd1 ? 2'b01 : 2'b00);
  assign cfg_ok = cfg_ctrl.size != 2'd3 && !(|(cur[0][1:0] & low)) && !(|(cur[1][1:0] & low))
               && !(|(minor[1:0] & low)) && minor != '0 && major != '0;

  dma_seq u_seq (
    .clk_i, .rst_ni,
    .trig_i(trig), .cfg_ok_i(cfg_ok),
    .minor_elems_i(minor >> cfg_ctrl.size), .major_i(major),
    .circ_i(cfg_ctrl.circ), .ack_i(mst_ack_i), .berr_i(mst_err_i),
    .state_o(state), .rd_ack_o(rd_ack), .step_o(step), .wrap_o(wrap),
    .set_done_o(set_done), .set_err_o(set_err), .set_ovr_o(set_ovr)
  );

  // element kept right-aligned between read and write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elem_q <= '0;
    else if (rd_ack) elem_q <= mst_rdata_i >> {cur[0][1:0], 3'b000};
  end

  assign busy_o      = state != ST_IDLE;
  assign mst_req_o   = busy_o;
  assign mst_we_o    = state == ST_WR;
  assign mst_addr_o  = mst_we_o ? cur[1] : cur[0];
  assign mst_be_o    = lane_mask(cfg_ctrl.size) << mst_addr_o[1:0];
  assign mst_wdata_o = elem_q << {cur[1][1:0], 3'b000};
  assign irq_o       = done_o && cfg_ctrl.irq_en;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mst_req_o,
  input logic          mst_we_o,
  input logic [AW-1:0] mst_addr_o,
  input logic [3:0]    mst_be_o,
  input logic [31:0]   mst_wdata_o,
  input logic          mst_ack_i,
  input logic          mst_err_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          ovr_o,
  input logic [1:0]    size_i
);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && !mst_ack_i |=> mst_req_o && $stable(mst_addr_o) && $stable(mst_we_o)
      && $stable(mst_be_o) && $stable(mst_wdata_o));
  // R4
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && !mst_we_o && mst_ack_i && !mst_err_i |=> mst_req_o && mst_we_o);
  // R4
  wr_not_repeated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && mst_we_o && mst_ack_i |=> !mst_we_o);
  // R2
  lane_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o |-> $countones(mst_be_o) == (32'd1 << size_i));
  // R8
  done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mst_req_o && mst_we_o && mst_ack_i));
  // R5
  end_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mst_ack_i));
  // R9
  ovr_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(busy_o));
  // R10
  err_leaves_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o);
endmodule

bind dma_engine dma_engine_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mst_req_o(mst_req_o), .mst_we_o(mst_we_o), .mst_addr_o(mst_addr_o),
  .mst_be_o(mst_be_o), .mst_wdata_o(mst_wdata_o),
  .mst_ack_i(mst_ack_i), .mst_err_i(mst_err_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ovr_o(ovr_o),
  .size_i(cfg_ctrl.size)
);

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        hw_req = 1'b0, tick = 1'b0, link = 1'b0;
  logic        req, we, ack = 1'b0, berr = 1'b0;
  logic [31:0] addr, wdata, rdata;
  logic [3:0]  be;
  logic        busy, done, err, ovr, irq;

  int errors = 0, checks = 0, cycles = 0;
  bit inj_err = 0;
  logic [7:0] mem [1024];
  logic [7:0] exp_mem [1024];
  logic [31:0] base_s, base_d, cur_s, cur_d;

  always #2.5 clk = ~clk;

  dma_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .hw_req_i(hw_req), .timer_tick_i(tick), .link_req_i(link),
    .mst_req_o(req), .mst_we_o(we), .mst_addr_o(addr), .mst_be_o(be),
    .mst_wdata_o(wdata), .mst_rdata_i(rdata), .mst_ack_i(ack), .mst_err_i(berr),
    .busy_o(busy), .done_o(done), .err_o(err), .ovr_o(ovr), .irq_o(irq)
  );

  always_comb begin
    rdata = '0;
    for (int b = 0; b < 4; b++) rdata[b*8 +: 8] = mem[{addr[9:2], 2'b00} + b];
  end

  // bus model: all decisions away from the active edge
  always @(negedge clk) begin
    ack  = 1'b0;
    berr = 1'b0;
    if (req) begin
      if (inj_err && !we) begin
        ack = 1'b1; berr = 1'b1; inj_err = 0;
      end else if ($urandom % 4 != 0) begin
        ack = 1'b1;
        if (we)
          for (int b = 0; b < 4; b++)
            if (be[b]) mem[{addr[9:2], 2'b00} + b] = wdata[b*8 +: 8];
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkctrl(int size, bit si, bit di, bit circ, bit ie,
                                         bit hw, bit tk, bit lk);
    return {23'd0, lk, tk, hw, ie, circ, di, si, 2'(size)};
  endfunction

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(logic [31:0] s, logic [31:0] d, logic [31:0] ctrl, int minor, int major);
    wr_reg(3'd0, s); wr_reg(3'd1, d); wr_reg(3'd2, ctrl);
    wr_reg(3'd3, {16'(major), 16'(minor)});
    base_s = s; base_d = d; cur_s = s; cur_d = d;
  endtask

  task automatic pulse(int which);  // 0 sw, 1 hw, 2 tick, 3 link
    if (which == 0) wr_reg(3'd4, 32'h1);
    else begin
      @(negedge clk);
      hw_req = (which == 1); tick = (which == 2); link = (which == 3);
      @(negedge clk);
      hw_req = 0; tick = 0; link = 0;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  // expected memory from the requirements
  task automatic model(int size, bit si, bit di, bit circ, int minor, int major);
    int es = 1 << size;
    logic [31:0] s = cur_s, d = cur_d;
    for (int e = 0; e < major * (minor / es); e++) begin
      for (int b = 0; b < es; b++) exp_mem[(d + b) & 1023] = exp_mem[(s + b) & 1023];
      if (si) s += es;
      if (di) d += es;
    end
    if (circ) begin cur_s = base_s; cur_d = base_d; end
    else begin cur_s = s; cur_d = d; end
  endtask

  task automatic chk_mem(string tag);
    int bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic run(int trig, int size, bit si, bit di, bit circ, int minor, int major, string tag);
    pulse(trig);
    model(size, si, di, circ, minor, major);
    wait_idle();
    chk_mem(tag);
    chk({tag, " done"}, done, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'($urandom); exp_mem[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset flags", {busy, done, err, ovr, irq, req}, 0);

    // R2 R3 R5 word copy, both incrementing, with interrupt
    setup(32'h010, 32'h200, mkctrl(2, 1, 1, 0, 1, 0, 0, 0), 8, 2);
    run(0, 2, 1, 1, 0, 8, 2, "R5 word block");
    chk("R8 irq with enable", irq, 1);
    wr_reg(3'd4, 32'h2);
    chk("R8 done cleared", {done, irq}, 0);

    // R3 fixed byte source into incrementing destination, no irq
    setup(32'h033, 32'h241, mkctrl(0, 0, 1, 0, 0, 0, 0, 0), 5, 1);
    run(0, 0, 0, 1, 0, 5, 1, "R3 fixed source");
    chk("R8 irq masked", irq, 0);
    wr_reg(3'd4, 32'h2);

    // R2 halfword from lane 0 to lane 2
    setup(32'h040, 32'h262, mkctrl(1, 1, 1, 0, 0, 0, 0, 0), 6, 1);
    run(0, 1, 1, 1, 0, 6, 1, "R2 halfword lanes");
    wr_reg(3'd4, 32'h2);

    // R5 single value
    setup(32'h051, 32'h283, mkctrl(0, 1, 1, 0, 0, 0, 0, 0), 1, 1);
    run(0, 0, 1, 1, 0, 1, 1, "R5 single value");
    wr_reg(3'd4, 32'h2);

    // R6 circular: second block rereads the same source into the same destination
    setup(32'h060, 32'h2a0, mkctrl(2, 1, 1, 1, 0, 0, 0, 0), 8, 1);
    run(0, 2, 1, 1, 1, 8, 1, "R6 circ first");
    wr_reg(3'd4, 32'h2);
    for (int i = 0; i < 8; i++) begin mem[32'h060 + i] = 8'(i + 8'h90); exp_mem[32'h060 + i] = mem[32'h060 + i]; end
    run(0, 2, 1, 1, 1, 8, 1, "R6 circ repeat");
    wr_reg(3'd4, 32'h2);

    // R6 non-circular: second block continues
    setup(32'h080, 32'h2c0, mkctrl(1, 1, 1, 0, 0, 0, 0, 0), 4, 1);
    run(0, 1, 1, 1, 0, 4, 1, "R6 linear first");
    wr_reg(3'd4, 32'h2);
    run(0, 1, 1, 1, 0, 4, 1, "R6 linear continue");
    wr_reg(3'd4, 32'h2);

    // R7 disabled pins do nothing
    setup(32'h090, 32'h2d0, mkctrl(2, 1, 1, 0, 0, 0, 0, 0), 4, 1);
    pulse(1); pulse(2); pulse(3);
    repeat (3) @(negedge clk);
    chk("R7 disabled triggers", {busy, done, req}, 0);
    chk_mem("R7 memory untouched");
    // R7 each enabled pin starts a block
    wr_reg(3'd2, mkctrl(2, 1, 1, 0, 0, 1, 0, 0));
    run(1, 2, 1, 1, 0, 4, 1, "R7 hw trigger");
    wr_reg(3'd4, 32'h2);
    wr_reg(3'd2, mkctrl(2, 1, 1, 0, 0, 0, 1, 0));
    run(2, 2, 1, 1, 0, 4, 1, "R7 tick trigger");
    wr_reg(3'd4, 32'h2);
    wr_reg(3'd2, mkctrl(2, 1, 1, 0, 0, 0, 0, 1));
    run(3, 2, 1, 1, 0, 4, 1, "R7 link trigger");
    wr_reg(3'd4, 32'h2);

    // R9 trigger during a block is dropped
    setup(32'h0a0, 32'h300, mkctrl(2, 1, 1, 0, 0, 1, 0, 0), 16, 4);
    pulse(0);
    model(2, 1, 1, 0, 16, 4);
    repeat (3) @(negedge clk);
    pulse(1);
    wait_idle();
    chk_mem("R9 block unaffected");
    chk("R9 overrun flag", ovr, 1);
    repeat (3) @(negedge clk);
    chk("R9 no second block", busy, 0);
    wr_reg(3'd4, 32'h8);
    chk("R9 overrun cleared", ovr, 0);
    wr_reg(3'd4, 32'h2);

    // R10 misaligned source refused
    setup(32'h0b2, 32'h340, mkctrl(2, 1, 1, 0, 0, 0, 0, 0), 4, 1);
    pulse(0);
    chk("R10 config error", {err, busy, done}, 3'b100);
    chk_mem("R10 no transfer");
    wr_reg(3'd4, 32'h4);
    chk("R10 error cleared", err, 0);
    // R10 zero major count
    setup(32'h0b0, 32'h340, mkctrl(2, 1, 1, 0, 0, 0, 0, 0), 4, 0);
    pulse(0);
    chk("R10 zero count", {err, busy}, 2'b10);
    wr_reg(3'd4, 32'h4);

    // R11 bus error on read aborts
    setup(32'h0c0, 32'h350, mkctrl(2, 1, 1, 0, 0, 0, 0, 0), 8, 1);
    inj_err = 1;
    pulse(0);
    wait_idle();
    chk("R11 bus error", {err, busy, done}, 3'b100);
    chk_mem("R11 nothing written");
    wr_reg(3'd4, 32'h4);

    // random configurations
    for (int n = 0; n < 24; n++) begin
      int sz = $urandom % 3;
      int es = 1 << sz;
      bit si = 1'($urandom), di = 1'($urandom), ci = 1'($urandom), ie = 1'($urandom);
      int tg = $urandom % 4;
      int mn = es * (1 + $urandom % 4);
      int mj = 1 + $urandom % 4;
      logic [31:0] s = (32'($urandom % 384)) & ~32'(es - 1);
      logic [31:0] d = (32'h200 + 32'($urandom % 384)) & ~32'(es - 1);
      setup(s, d, mkctrl(sz, si, di, ci, ie, tg == 1, tg == 2, tg == 3), mn, mj);
      run(tg, sz, si, di, ci, mn, mj, "R5 random block");
      chk("R8 random irq", irq, 32'(ie));
      wr_reg(3'd4, 32'h2);
    end

    finish_run();
  end
endmodule